// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches an externally supplied 16-bit free-running timer count and compares it with a 16-bit compare value held in two byte registers. The counter advances only on tick cycles, and a match is taken only on a tick. When the enabled compare value equals the count, the unit raises a compare flag and drives a dedicated compare output to a level chosen by a control bit. Software then routes that output to a port line.

Software reaches the unit through a byte-wide register port. Writing the high byte of the compare value suspends matching until the low byte is written. This keeps a half-updated 16-bit value from producing a false match. Clearing the flag takes two steps. Software first reads the status byte while the flag is set, which arms the clear. A later low-byte write then clears the flag. Reset leaves the compare value and the flag as they were.

Register map (addr_i): 0 = compare high byte, 1 = compare low byte, 2 = status (bit 7 = flag, other bits read 0), 3 = control (bit 0 = output level, other bits read 0).

Top module: `tmr_ocmp`

## Requirements
- R1: Reset (rst_ni low) leaves the compare value and the flag unchanged. It clears the compare output, the level bit, the arm state and the inhibit state.
- R2: Reads return the compare high byte at addr 0 and the low byte at addr 1. At addr 2 the flag appears in bit 7, and at addr 3 the level bit appears in bit 0. Unused bits read 0.
- R3: After a high-byte write, no match sets the flag until a low-byte write has occurred.
- R4: A tick cycle with cnt_i equal to the compare value and no inhibit sets flag_o from the next cycle.
- R5: A cycle with tick_i low never sets the flag, even when cnt_i equals the compare value.
- R6: On a match, cmp_pin_o takes the level bit's value from the next cycle.
- R7: A status read while the flag is set, followed by a low-byte write, clears the flag.
- R8: A low-byte write with no armed status read before it leaves a set flag set.
- R9: A status read made while the flag is clear does not arm a clear for a flag that is set afterwards.
- R10: When a match and a clearing low-byte write fall in the same cycle, the flag stays set and the arm is used up.
- R11: cmp_pin_o keeps its level between matches. Level-bit writes and flag clears do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter increment cycle |
| cnt_i | input | 16 | Free-running counter value |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| flag_o | output | 1 | Compare flag |
| cmp_pin_o | output | 1 | Compare output level |

## Verification
A match can fall in the same cycle as the low-byte write that would clear an armed flag. In that cycle the rule that sets the flag and the rule that clears it act together. The bench provokes this by arming the flag with a status read. It then drives, in a single cycle, a low-byte write that leaves the compare value unchanged together with a tick whose count equals that value. It judges the result by checking that the flag is still set afterwards. It then checks that a second low-byte write also leaves the flag set, which shows that the arm was used up.

// File: rtl/tmr_ocmp_pkg.sv
package tmr_ocmp_pkg;
  typedef enum logic [1:0] {
    A_CMP_HI = 2'd0,
    A_CMP_LO = 2'd1,
    A_STAT   = 2'd2,
    A_CTRL   = 2'd3
  } reg_addr_e;

  localparam int unsigned STAT_FLAG_BIT = 7;
  localparam int unsigned CTRL_LVL_BIT  = 0;
endpackage

// File: rtl/tmr_ocmp_cmpreg.sv
module tmr_ocmp_cmpreg #(
  parameter int unsigned DW = 8,
  parameter int unsigned NB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    byte_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NB*DW-1:0] cmp_o,
  output logic             inhibit_o
);
  // compare bytes are intentionally not reset
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (byte_we_i[g]) cmp_o[g*DW +: DW] <= wdata_i;
    end
  end

  // high byte arms the inhibit, low byte releases it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           inhibit_o <= 1'b0;
    else if (byte_we_i[0]) inhibit_o <= 1'b0;
    else if (byte_we_i[NB-1]) inhibit_o <= 1'b1;
  end
endmodule

// File: rtl/tmr_ocmp_flag.sv
module tmr_ocmp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic lo_wr_i,
  output logic flag_o,
  output logic armed_o
);
  // flag survives reset; a new match wins over a clear
  always_ff @(posedge clk_i) begin
    if (set_i)                   flag_o <= 1'b1;
    else if (armed_o && lo_wr_i) flag_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  armed_o <= 1'b0;
    else if (lo_wr_i)             armed_o <= 1'b0;
    else if (stat_rd_i && flag_o) armed_o <= 1'b1;
  end
endmodule

// File: rtl/tmr_ocmp_match.sv
module tmr_ocmp_match #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          inhibit_i,
  input  logic          level_i,
  output logic          hit_o,
  output logic          pin_o
);
  assign hit_o = tick_i && !inhibit_i && (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pin_o <= 1'b0;
    else if (hit_o) pin_o <= level_i;
  end
endmodule

// File: rtl/tmr_ocmp.sv
module tmr_ocmp
  import tmr_ocmp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            flag_o,
  output logic            cmp_pin_o
);
  localparam int unsigned NB = 2;
  localparam int unsigned CW = NB * DW;

  logic [CW-1:0] cmp;
  logic          inhibit, armed, hit, level;
  logic          hi_wr, lo_wr, ctrl_wr, stat_rd;

  assign hi_wr   = wr_en_i && (addr_i == A_CMP_HI);
  assign lo_wr   = wr_en_i && (addr_i == A_CMP_LO);
  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
  assign stat_rd = rd_en_i && (addr_i == A_STAT);

  tmr_ocmp_cmpreg #(.DW(DW), .NB(NB)) u_cmpreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_we_i ({hi_wr, lo_wr}),
    .wdata_i   (wdata_i),
    .cmp_o     (cmp),
    .inhibit_o (inhibit)
  );

  tmr_ocmp_match #(.CW(CW)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cnt_i     (cnt_i),
    .cmp_i     (cmp),
    .inhibit_i (inhibit),
    .level_i   (level),
    .hit_o     (hit),
    .pin_o     (cmp_pin_o)
  );

  tmr_ocmp_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (hit),
    .stat_rd_i (stat_rd),
    .lo_wr_i   (lo_wr),
    .flag_o    (flag_o),
    .armed_o   (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      level <= 1'b0;
    else if (ctrl_wr) level <= wdata_i[CTRL_LVL_BIT];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CMP_HI: rdata_o = cmp[CW-1 -: DW];
      A_CMP_LO: rdata_o = cmp[DW-1:0];
      A_STAT:   rdata_o[STAT_FLAG_BIT] = flag_o;
      default:  rdata_o[CTRL_LVL_BIT] = level;
    endcase
  end
endmodule

module tmr_ocmp_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] cmp,
  input logic          inhibit,
  input logic          armed,
  input logic          lo_wr,
  input logic          level,
  input logic          flag_o,
  input logic          cmp_pin_o
);
  a_r3_inhibit_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit && !flag_o) |=> !flag_o);

  a_r4_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !inhibit && cnt_i == cmp) |=> flag_o);

  a_r5_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !flag_o) |=> !flag_o);

  a_r6_pin_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !inhibit && cnt_i == cmp) |=> (cmp_pin_o == $past(level)));

  a_r8_clear_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(armed && lo_wr)) |=> flag_o);

  a_r11_pin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && !inhibit && cnt_i == cmp) |=> $stable(cmp_pin_o));
endmodule

bind tmr_ocmp tmr_ocmp_chk #(.CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .cnt_i     (cnt_i),
  .cmp       (cmp),
  .inhibit   (inhibit),
  .armed     (armed),
  .lo_wr     (lo_wr),
  .level     (level),
  .flag_o    (flag_o),
  .cmp_pin_o (cmp_pin_o)
);

// File: tb/tmr_ocmp_test.sv
module tmr_ocmp_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        flag_o, cmp_pin_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  tmr_ocmp uut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic do_tick(logic [15:0] v);
    @(negedge clk_i);
    cnt_i = v; tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic clear_flag(logic [7:0] lo);
    logic [7:0] d;
    bus_rd(2'd2, d);
    bus_wr(2'd1, lo);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R1 pin after reset", 16'(cmp_pin_o), 16'h0);
    bus_rd(2'd3, d);
    check("R1 level after reset", 16'(d), 16'h0);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    bus_wr(2'd0, 8'h12);
    bus_wr(2'd1, 8'h34);
    bus_rd(2'd0, d);
    check("R2 high byte", 16'(d), 16'h12);
    bus_rd(2'd1, d);
    check("R2 low byte", 16'(d), 16'h34);
    clear_flag(8'h34);
    bus_rd(2'd2, d);
    check("R2 status flag clear", 16'(d), 16'h00);
  endtask

  task automatic t_no_tick();
    @(negedge clk_i);
    cnt_i = 16'h1234;
    repeat (3) @(negedge clk_i);
    check("R5 no tick no match", 16'(flag_o), 16'h0);
  endtask

  task automatic t_match();
    bus_wr(2'd3, 8'h01);
    do_tick(16'h1233);
    check("R4 non-equal tick", 16'(flag_o), 16'h0);
    do_tick(16'h1234);
    check("R4 equal tick sets flag", 16'(flag_o), 16'h1);
    check("R6 pin takes level 1", 16'(cmp_pin_o), 16'h1);
  endtask

  task automatic t_noarm_then_clear();
    logic [7:0] d;
    bus_wr(2'd1, 8'h34);
    check("R8 unarmed low write", 16'(flag_o), 16'h1);
    bus_rd(2'd2, d);
    check("R2 status flag set", 16'(d), 16'h80);
    bus_wr(2'd1, 8'h34);
    check("R7 armed clear", 16'(flag_o), 16'h0);
  endtask

  task automatic t_read_while_clear();
    logic [7:0] d;
    bus_rd(2'd2, d);
    do_tick(16'h1234);
    check("R9 set after early read", 16'(flag_o), 16'h1);
    bus_wr(2'd1, 8'h34);
    check("R9 early read did not arm", 16'(flag_o), 16'h1);
    clear_flag(8'h34);
    check("R7 clear again", 16'(flag_o), 16'h0);
  endtask

  task automatic t_inhibit();
    bus_wr(2'd0, 8'h12);
    do_tick(16'h1234);
    check("R3 inhibited after high write", 16'(flag_o), 16'h0);
    bus_wr(2'd1, 8'h34);
    do_tick(16'h1234);
    check("R3 enabled after low write", 16'(flag_o), 16'h1);
  endtask

  task automatic t_pin_hold();
    bus_wr(2'd3, 8'h00);
    check("R11 level write keeps pin", 16'(cmp_pin_o), 16'h1);
    clear_flag(8'h34);
    check("R11 clear keeps pin", 16'(cmp_pin_o), 16'h1);
    do_tick(16'h1234);
    check("R6 pin takes level 0", 16'(cmp_pin_o), 16'h0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    bus_rd(2'd2, d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 2'd1; wdata_i = 8'h34;
    cnt_i = 16'h1234; tick_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
    check("R10 match wins over clear", 16'(flag_o), 16'h1);
    bus_wr(2'd1, 8'h34);
    check("R10 arm consumed", 16'(flag_o), 16'h1);
    clear_flag(8'h34);
    check("R7 clear after collision", 16'(flag_o), 16'h0);
  endtask

  task automatic t_reset_keep();
    logic [7:0] d;
    bus_wr(2'd3, 8'h01);
    bus_wr(2'd0, 8'hAB);
    bus_wr(2'd1, 8'hCD);
    do_tick(16'hABCD);
    check("R4 match on new value", 16'(flag_o), 16'h1);
    #2 rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 flag kept", 16'(flag_o), 16'h1);
    check("R1 pin cleared", 16'(cmp_pin_o), 16'h0);
    bus_rd(2'd0, d);
    check("R1 high byte kept", 16'(d), 16'hAB);
    bus_rd(2'd1, d);
    check("R1 low byte kept", 16'(d), 16'hCD);
    bus_rd(2'd3, d);
    check("R1 level cleared", 16'(d), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_readback();
    t_no_tick();
    t_match();
    t_noarm_then_clear();
    t_read_while_clear();
    t_inhibit();
    t_pin_hold();
    t_collide();
    t_reset_keep();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule